// File: doc/BRIEF.md
# Delayed Command Parity Checker

This block watches the address and command lines that a memory register forwards only when a chip select is active. It checks them against a parity bit that the controller sends one clock after the command itself. The block registers the parity of each qualifying command. On the next rising edge it compares that value with the late parity bit. When the two disagree, it pulls an active-low error flag for a fixed number of cycles, at a fixed distance from the offending command.

The covered bits are the address, the bank address, and the row strobe, column strobe and write enable lines. A command counts as qualifying when at least one chip select is low. Cycles with every chip select high are not checked, and the parity bit that follows them is ignored. The error pulse normally starts three clocks after the command and lasts two clocks. An asynchronous active-low reset clears every pending result and returns the flag high at once.

Top module: `dcp_parity_checker`

## Requirements
- R1: Parity is even over the command fields {addr, bank, ras_n, cas_n, we_n} together with par_in. When the XOR of all those bits is 0, no error is reported, for any values of the fields.
- R2: par_in is sampled on the rising edge that immediately follows the edge that captured the command it covers. It is compared only against that command.
- R3: A command captured while every bit of cs_n is 1 is not checked. The par_in value on the following edge has no effect on err_n.
- R4: If the command captured at edge n fails the R1 rule, err_n is 0 during the cycle that begins at edge n+3.
- R5: An isolated error holds err_n at 0 for exactly two cycles, after edges n+3 and n+4. err_n returns to 1 after edge n+5.
- R6: Errors on successive commands extend the low period. err_n stays 0 without a gap until two cycles after the pulse of the last error starts.
- R7: While rst_n is 0, err_n is 1 without waiting for a clock. Errors that were pending or in progress when reset was applied never appear after release.
- R8: After reset is released, no check is made before the first qualifying command. A wrong par_in on the first edge after release has no effect on err_n.
- R9: Any single cs_n bit at 0, or several at once, qualifies the command for checking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every capture happens on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Address lines gated by the chip selects |
| bank | input | BANK_W | Bank address lines gated by the chip selects |
| ras_n | input | 1 | Row strobe command line |
| cas_n | input | 1 | Column strobe command line |
| we_n | input | 1 | Write enable command line |
| cs_n | input | NUM_CS | Chip selects, active low |
| par_in | input | 1 | Even parity for the command of the previous cycle |
| err_n | output | 1 | Parity error flag, active low |

## Verification
If the captured parity or the qualify flag is stored wrongly, err_n is wrong three cycles after the command. The fault shows either as a pulse the command did not earn or as a missing pulse. A pipeline that is one stage too short or too long moves every pulse by one cycle. The scoreboard catches that on the first error command. A fault in the width counter shows at the first isolated error: the flag is high one cycle early or one cycle late. With random command patterns under correct parity, a covered bit left out of the reduction raises a spurious pulse within a few commands.

// File: rtl/dcp_pkg.sv
package dcp_pkg;

    localparam int unsigned CTRL_BITS = 3;

    typedef struct packed {
        logic valid;
        logic parity;
    } dcp_cap_t;

endpackage

// File: rtl/dcp_capture.sv
module dcp_capture
    import dcp_pkg::*;
#(
    parameter int unsigned CMD_W  = 22,
    parameter int unsigned NUM_CS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CMD_W-1:0]  cmd,
    input  logic [NUM_CS-1:0] cs_n,
    output dcp_cap_t          cap_q
);

    logic [CMD_W:0] chain;
    dcp_cap_t       cap_d;
    dcp_cap_t       state_q;

    assign chain[0] = 1'b0;

    for (genvar gi = 0; gi < CMD_W; gi++) begin : g_chain
        assign chain[gi+1] = chain[gi] ^ cmd[gi];
    end

    always_comb begin
        cap_d        = state_q;
        cap_d.valid  = ~(&cs_n);
        cap_d.parity = chain[CMD_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= cap_d;
        end
    end

    assign cap_q = state_q;

endmodule

// File: rtl/dcp_compare.sv
module dcp_compare
    import dcp_pkg::*;
#(
    parameter int unsigned ERR_LATENCY = 3
) (
    input  logic     clk,
    input  logic     rst_n,
    input  dcp_cap_t cap,
    input  logic     par_in,
    output logic     mism_q,
    output logic     late_err
);

    localparam int unsigned DLY = (ERR_LATENCY > 3) ? ERR_LATENCY - 2 : 1;

    typedef struct packed {
        logic           mism;
        logic [DLY-1:0] dly;
    } cmp_state_t;

    cmp_state_t st_d;
    cmp_state_t st_q;

    always_comb begin
        st_d        = st_q;
        st_d.mism   = cap.valid & (cap.parity ^ par_in);
        st_d.dly[0] = st_q.mism;
        for (int i = 1; i < int'(DLY); i++) begin
            st_d.dly[i] = st_q.dly[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mism_q   = st_q.mism;
    assign late_err = st_q.dly[DLY-1];

endmodule

// File: rtl/dcp_pulse.sv
module dcp_pulse #(
    parameter int unsigned ERR_WIDTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic late_err,
    output logic err_n
);

    localparam int unsigned CNT_W = $clog2(ERR_WIDTH + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(ERR_WIDTH);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pulse_state_t;

    pulse_state_t ps_d;
    pulse_state_t ps_q;

    always_comb begin
        ps_d = ps_q;
        if (late_err) begin
            ps_d.cnt = LOAD;
        end else if (ps_q.cnt != '0) begin
            ps_d.cnt = ps_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps_q <= '0;
        end else begin
            ps_q <= ps_d;
        end
    end

    assign err_n = (ps_q.cnt == '0);

endmodule

// File: rtl/dcp_parity_checker.sv
module dcp_parity_checker
    import dcp_pkg::*;
#(
    parameter int unsigned ADDR_W      = 16,
    parameter int unsigned BANK_W      = 3,
    parameter int unsigned NUM_CS      = 2,
    parameter int unsigned ERR_LATENCY = 3,
    parameter int unsigned ERR_WIDTH   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BANK_W-1:0] bank,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [NUM_CS-1:0] cs_n,
    input  logic              par_in,
    output logic              err_n
);

    localparam int unsigned CMD_W = ADDR_W + BANK_W + CTRL_BITS;

    logic [CMD_W-1:0] cmd_bus;
    dcp_cap_t         cap_q;
    logic             mism_q;
    logic             late_err;

    assign cmd_bus = {addr, bank, ras_n, cas_n, we_n};

    dcp_capture #(
        .CMD_W  (CMD_W),
        .NUM_CS (NUM_CS)
    ) u_capture (
        .clk   (clk),
        .rst_n (rst_n),
        .cmd   (cmd_bus),
        .cs_n  (cs_n),
        .cap_q (cap_q)
    );

    dcp_compare #(
        .ERR_LATENCY (ERR_LATENCY)
    ) u_compare (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap      (cap_q),
        .par_in   (par_in),
        .mism_q   (mism_q),
        .late_err (late_err)
    );

    dcp_pulse #(
        .ERR_WIDTH (ERR_WIDTH)
    ) u_pulse (
        .clk      (clk),
        .rst_n    (rst_n),
        .late_err (late_err),
        .err_n    (err_n)
    );

endmodule

// File: rtl/dcp_parity_checker_sva.sv
module dcp_parity_checker_sva (
    input logic clk,
    input logic rst_n,
    input logic err_n,
    input logic par_in,
    input logic cap_valid,
    input logic cap_parity,
    input logic mism,
    input logic late_err
);

    // R2: a qualified command with a disagreeing late parity bit is flagged one edge on
    a_r2_late_compare: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid && (cap_parity != par_in)) |=> mism);

    // R3: an unqualified capture never produces a mismatch
    a_r3_unqualified_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_valid |=> !mism);

    // R4: the delayed error drives the flag low on the next edge
    a_r4_flag_follows: assert property (@(posedge clk) disable iff (!rst_n)
        late_err |=> !err_n);

    // R4: the flag only falls because of a delayed error
    a_r4_no_spurious_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_n) |-> $past(late_err));

    // R5: a pulse lasts at least two cycles
    a_r5_min_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_n) |=> !err_n);

    // R7: flag inactive while reset is held
    always @(negedge clk) begin
        if (!rst_n) begin
            a_r7_reset_high: assert (err_n);
        end
    end

endmodule

bind dcp_parity_checker dcp_parity_checker_sva u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .err_n      (err_n),
    .par_in     (par_in),
    .cap_valid  (cap_q.valid),
    .cap_parity (cap_q.parity),
    .mism       (mism_q),
    .late_err   (late_err)
);

// File: tb/dcp_parity_checker_test.sv
module dcp_parity_checker_test;

    localparam int ADDR_W = 16;
    localparam int BANK_W = 3;
    localparam int NUM_CS = 2;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [ADDR_W-1:0] addr;
    logic [BANK_W-1:0] bank;
    logic              ras_n, cas_n, we_n;
    logic [NUM_CS-1:0] cs_n;
    logic              par_in;
    logic              err_n;

    dcp_parity_checker #(
        .ADDR_W (ADDR_W),
        .BANK_W (BANK_W),
        .NUM_CS (NUM_CS)
    ) uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (addr),
        .bank   (bank),
        .ras_n  (ras_n),
        .cas_n  (cas_n),
        .we_n   (we_n),
        .cs_n   (cs_n),
        .par_in (par_in),
        .err_n  (err_n)
    );

    always #5 clk = ~clk;

    typedef struct {
        int    edge_no;
        bit    err;
        string tag;
    } item_t;

    item_t q[$];
    int    edge_cnt = 0;
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    mon_en = 1'b0;
    bit    lowmap[4096];
    string tagmap[4096];

    // bench model of the previous command
    bit    pv = 1'b0;
    bit    pp = 1'b0;
    bit    pf = 1'b0;
    string ptag = "R8";

    always @(posedge clk) edge_cnt <= edge_cnt + 1;

    task automatic check(input logic act, input logic exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: err_n=%b expected %b at edge %0d", tag, act, exp, edge_cnt);
        end
    endtask

    // driver: one command per cycle, parity of the previous command alongside
    task automatic drive(input logic [ADDR_W-1:0] a, input logic [BANK_W-1:0] b,
                         input logic r, input logic c, input logic w,
                         input logic [NUM_CS-1:0] cs, input bit flip, input string tag);
        item_t it;
        @(negedge clk);
        it.edge_no = edge_cnt + 1;
        it.err     = pv && pf;
        it.tag     = ptag;
        par_in     = pv ? (pp ^ pf) : ~pp;
        q.push_back(it);
        addr  = a;
        bank  = b;
        ras_n = r;
        cas_n = c;
        we_n  = w;
        cs_n  = cs;
        pv    = ~(&cs);
        pp    = ^{a, b, r, c, w};
        pf    = flip;
        ptag  = tag;
    endtask

    task automatic rnd(input logic [NUM_CS-1:0] cs, input bit flip, input string tag);
        drive(ADDR_W'($urandom), BANK_W'($urandom), 1'($urandom), 1'($urandom),
              1'($urandom), cs, flip, tag);
    endtask

    task automatic rnd_q(input bit flip, input string tag);
        logic [NUM_CS-1:0] cs;
        cs = NUM_CS'($urandom);
        if (&cs) cs[0] = 1'b0;
        rnd(cs, flip, tag);
    endtask

    // monitor: pop decisions, build expected flag, compare each cycle
    always @(negedge clk) begin
        if (mon_en) begin
            while (q.size() > 0 && q[0].edge_no <= edge_cnt) begin
                item_t it;
                int    e;
                it = q.pop_front();
                e  = it.edge_no;
                if (it.err) begin
                    lowmap[e+2] = 1'b1;
                    lowmap[e+3] = 1'b1;
                    tagmap[e+2] = it.tag;
                    tagmap[e+3] = it.tag;
                    if (!lowmap[e+4]) tagmap[e+4] = "R5";
                end else if (tagmap[e+2] == "") begin
                    tagmap[e+2] = it.tag;
                end
            end
            check(err_n, !lowmap[edge_cnt],
                  (tagmap[edge_cnt] == "") ? "R1" : tagmap[edge_cnt]);
        end
    end

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog: run did not end, actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        addr = '0; bank = '0; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
        cs_n = '1; par_in = 1'b0;
        #23;
        check(err_n, 1'b1, "R7");
        @(negedge clk);
        rst_n  = 1'b1;
        mon_en = 1'b1;

        // R8: first cycles after release, no qualified command, wrong parity
        rnd('1, 1'b1, "R8");
        rnd('1, 1'b1, "R8");
        // R1: random qualified commands with correct even parity
        for (int i = 0; i < 24; i++) rnd_q(1'b0, "R1");
        // R4/R5: one isolated error
        rnd_q(1'b1, "R4");
        for (int i = 0; i < 6; i++) rnd_q(1'b0, "R5");
        // R3: unqualified commands with wrong parity
        for (int i = 0; i < 5; i++) rnd('1, 1'b1, "R3");
        for (int i = 0; i < 5; i++) rnd_q(1'b0, "R3");
        // R9: each single chip select low, then all low
        for (int k = 0; k < NUM_CS; k++) begin
            logic [NUM_CS-1:0] cs;
            cs = '1;
            cs[k] = 1'b0;
            rnd(cs, 1'b1, "R9");
            for (int i = 0; i < 5; i++) rnd_q(1'b0, "R9");
        end
        rnd('0, 1'b1, "R9");
        for (int i = 0; i < 5; i++) rnd_q(1'b0, "R9");
        // R6: back-to-back errors merge
        for (int i = 0; i < 3; i++) rnd_q(1'b1, "R6");
        for (int i = 0; i < 6; i++) rnd_q(1'b0, "R6");
        // R2: alternating pattern pins the parity to the right command
        for (int i = 0; i < 20; i++) rnd_q(i[0] ^ i[2], "R2");
        for (int i = 0; i < 8; i++) rnd('1, 1'b0, "R3");
        mon_en = 1'b0;

        // R7: reset while the pulse is active
        rnd_q(1'b1, "R7");
        rnd('1, 1'b0, "R7");
        rnd('1, 1'b0, "R7");
        rnd('1, 1'b0, "R7");
        @(negedge clk);
        check(err_n, 1'b0, "R4");
        #1 rst_n = 1'b0;
        #1 check(err_n, 1'b1, "R7");
        @(negedge clk);
        rst_n = 1'b1;
        pv = 1'b0;
        for (int i = 0; i < 6; i++) begin
            rnd('1, 1'b0, "R7");
            check(err_n, 1'b1, "R7");
        end

        // R7: reset while the error is still in the pipeline
        rnd_q(1'b1, "R7");
        rnd('1, 1'b0, "R7");
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        pv = 1'b0;
        for (int i = 0; i < 6; i++) begin
            rnd('1, 1'b0, "R7");
            check(err_n, 1'b1, "R7");
        end
        q.delete();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule